// File: doc/BRIEF.md
# Fixed-Point Format Converter

This block re-expresses a fixed-point number in a different fixed-point format. Both formats are fixed at elaboration: each has a total width and an integer width, and the fraction width is the difference of the two. The input may be signed or unsigned, and so may the output. The block first lines up the binary points of the two formats. It then removes the surplus fraction bits using one of seven rounding or truncation rules, chosen per sample. Finally it brings the result into the output range using one of five overflow rules, also chosen per sample.

Rounding always comes first. Overflow is judged on the rounded value, so a rounding carry can itself push a value out of range. A flag marks every sample whose value the overflow rule altered. Results are registered and appear one cycle after the input strobe. For an unsigned output, every saturating rule maps a negative value to zero.

Top module: `fxq_convert`

## Requirements
- R1: An input exactly representable in the output format (default formats: 12-bit input with 7 fraction bits, 8-bit output with 5 fraction bits, both signed) leaves with the same real value under every rounding code, with the flag low.
- R2: Rounding code 0, and the unused code 7, truncate toward minus infinity (floor).
- R3: Rounding code 1 truncates toward zero.
- R4: Rounding code 2 rounds to nearest, with exact halves going toward plus infinity.
- R5: Rounding code 3 rounds to nearest, with exact halves going toward zero.
- R6: Rounding code 4 rounds to nearest, with exact halves going toward minus infinity.
- R7: Rounding code 5 rounds to nearest, with exact halves going away from zero.
- R8: Rounding code 6 rounds to nearest, with exact halves going to the even result.
- R9: Overflow code 0, and unused codes 5 to 7, wrap in two's complement by keeping the low output bits.
- R10: Overflow code 1 clamps to the largest or smallest output value. Overflow is judged after rounding, so a rounding carry past the maximum is clamped and flagged.
- R11: Overflow code 2 returns zero for an out-of-range value.
- R12: Overflow code 3 clamps to plus or minus the largest positive value. A rounded value equal to the most negative code also becomes minus the largest positive value and is flagged.
- R13: Overflow code 4 keeps the sign of an out-of-range value and wraps its magnitude modulo 2^(W-1).
- R14: o_valid follows i_valid one cycle later. o_ovf is high only with o_valid, and only when the overflow rule changed the value. o_data holds its value while no input is valid. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Input sample strobe |
| i_data | input | W_IN | Input fixed-point value |
| i_qmode | input | 3 | Rounding rule code |
| i_omode | input | 3 | Overflow rule code |
| o_valid | output | 1 | Output sample strobe |
| o_data | output | W | Converted value |
| o_ovf | output | 1 | The overflow rule altered this sample |

## Verification
The hardest cases to reach are those where the rounding carry alone crosses the range limit, and the symmetric-clamp case where a value rounds onto exactly the most negative code. Both occur only for a handful of input codes, and only under particular rounding rules. The stimulus therefore sweeps every input code under every rounding rule, and again under every overflow rule. It also inserts idle cycles at intervals, to check that the output holds and the strobe is quiet.

// File: rtl/fxq_pkg.sv
package fxq_pkg;
  typedef enum logic [2:0] {
    QM_FLOOR     = 3'd0,
    QM_TOZERO    = 3'd1,
    QM_HALF_UP   = 3'd2,
    QM_HALF_IN   = 3'd3,
    QM_HALF_DOWN = 3'd4,
    QM_HALF_OUT  = 3'd5,
    QM_HALF_EVEN = 3'd6,
    QM_SPARE     = 3'd7
  } qmode_e;

  typedef enum logic [2:0] {
    OM_WRAP     = 3'd0,
    OM_CLAMP    = 3'd1,
    OM_ZERO     = 3'd2,
    OM_CLAMPSYM = 3'd3,
    OM_WRAPSM   = 3'd4,
    OM_SPARE5   = 3'd5,
    OM_SPARE6   = 3'd6,
    OM_SPARE7   = 3'd7
  } omode_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fxq_align.sv
module fxq_align #(
  parameter int W_IN      = 12,
  parameter int IN_SIGNED = 1,
  parameter int SHIFT_L   = 0,
  parameter int WX        = 16
) (
  input  logic [W_IN-1:0]        i_val,
  output logic signed [WX-1:0]   o_val
);
  logic signed [WX-1:0] ext;

  generate
    if (IN_SIGNED != 0) begin : g_sext
      assign ext = {{(WX-W_IN){i_val[W_IN-1]}}, i_val};
    end else begin : g_zext
      assign ext = {{(WX-W_IN){1'b0}}, i_val};
    end
  endgenerate

  assign o_val = ext <<< SHIFT_L;
endmodule

// File: rtl/fxq_round.sv
module fxq_round
  import fxq_pkg::*;
#(
  parameter int WX   = 16,
  parameter int DROP = 2
) (
  input  logic signed [WX-1:0] i_val,
  input  logic [2:0]           i_mode,
  output logic signed [WX-1:0] o_val
);
  generate
    if (DROP == 0) begin : g_pass
      assign o_val = i_val;
    end else begin : g_drop
      logic signed [WX-1:0] floor_v;
      logic                 half_bit;
      logic                 rest_nz;
      logic                 any_nz;
      logic                 neg;
      logic                 inc;
      qmode_e               mode;

      assign floor_v  = i_val >>> DROP;
      assign half_bit = i_val[DROP-1];
      if (DROP > 1) begin : g_rest
        assign rest_nz = |i_val[DROP-2:0];
      end else begin : g_norest
        assign rest_nz = 1'b0;
      end
      assign any_nz = half_bit | rest_nz;
      assign neg    = i_val[WX-1];
      assign mode   = qmode_e'(i_mode);

      always_comb begin
        case (mode)
          QM_TOZERO:    inc = neg & any_nz;
          QM_HALF_UP:   inc = half_bit;
          QM_HALF_IN:   inc = half_bit & (rest_nz | neg);
          QM_HALF_DOWN: inc = half_bit & rest_nz;
          QM_HALF_OUT:  inc = half_bit & (rest_nz | ~neg);
          QM_HALF_EVEN: inc = half_bit & (rest_nz | floor_v[0]);
          default:      inc = 1'b0;
        endcase
      end

      assign o_val = floor_v + {{(WX-1){1'b0}}, inc};

      always_comb begin
        if (mode == QM_FLOOR || mode == QM_SPARE)
          AST_FLOOR_NEVER_UP: assert (o_val <= (i_val >>> DROP)); // R2
      end
    end
  endgenerate
endmodule

// File: rtl/fxq_ovf.sv
module fxq_ovf
  import fxq_pkg::*;
#(
  parameter int WX         = 16,
  parameter int W          = 8,
  parameter int OUT_SIGNED = 1
) (
  input  logic signed [WX-1:0] i_val,
  input  logic [2:0]           i_mode,
  output logic [W-1:0]         o_val,
  output logic                 o_flag
);
  localparam logic signed [WX-1:0] ONE  = 1;
  localparam logic signed [WX-1:0] MAXV = (OUT_SIGNED != 0) ? ((ONE <<< (W-1)) - ONE)
                                                            : ((ONE <<< W) - ONE);
  localparam logic signed [WX-1:0] MINV = (OUT_SIGNED != 0) ? -(ONE <<< (W-1)) : '0;
  localparam logic signed [WX-1:0] NLIM = (OUT_SIGNED != 0) ? -MAXV : '0;

  omode_e               mode;
  logic                 hi, lo, edge_min, neg;
  logic [W-1:0]         wrapped;
  logic signed [WX-1:0] mag_full;
  logic [W-1:0]         sm_pos, sm_val;

  assign mode     = omode_e'(i_mode);
  assign hi       = i_val > MAXV;
  assign lo       = i_val < MINV;
  assign edge_min = (OUT_SIGNED != 0) && (i_val == MINV);
  assign neg      = i_val[WX-1];
  assign wrapped  = i_val[W-1:0];
  assign mag_full = neg ? -i_val : i_val;

  generate
    if (OUT_SIGNED != 0) begin : g_sm
      assign sm_pos = {1'b0, mag_full[W-2:0]};
      assign sm_val = neg ? (~sm_pos + 1'b1) : sm_pos;
    end else begin : g_nosm
      assign sm_pos = wrapped;
      assign sm_val = wrapped;
    end
  endgenerate

  always_comb begin
    o_val  = wrapped;
    o_flag = hi | lo;
    case (mode)
      OM_CLAMP: begin
        if (hi)      o_val = MAXV[W-1:0];
        else if (lo) o_val = MINV[W-1:0];
      end
      OM_ZERO: begin
        if (hi | lo) o_val = '0;
      end
      OM_CLAMPSYM: begin
        o_flag = hi | lo | edge_min;
        if (hi)                 o_val = MAXV[W-1:0];
        else if (lo | edge_min) o_val = NLIM[W-1:0];
      end
      OM_WRAPSM: begin
        if (hi | lo) o_val = sm_val;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!o_flag)
      AST_UNFLAGGED_EXACT: assert (o_val == wrapped && !hi && !lo); // R14
    if (mode == OM_CLAMPSYM && OUT_SIGNED != 0)
      AST_SYM_NO_MIN: assert (o_val != MINV[W-1:0]); // R12
    if (mode == OM_ZERO && (hi | lo))
      AST_ZERO_ON_OVF: assert (o_val == '0); // R11
  end
endmodule

// File: rtl/fxq_convert.sv
module fxq_convert
  import fxq_pkg::*;
#(
  parameter int W_IN       = 12,
  parameter int I_IN       = 5,
  parameter int IN_SIGNED  = 1,
  parameter int W          = 8,
  parameter int I          = 3,
  parameter int OUT_SIGNED = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_valid,
  input  logic [W_IN-1:0] i_data,
  input  logic [2:0]      i_qmode,
  input  logic [2:0]      i_omode,
  output logic            o_valid,
  output logic [W-1:0]    o_data,
  output logic            o_ovf
);
  localparam int F_IN    = W_IN - I_IN;
  localparam int F       = W - I;
  localparam int SHIFT_L = (F > F_IN) ? (F - F_IN) : 0;
  localparam int DROP    = (F_IN > F) ? (F_IN - F) : 0;
  localparam int WX      = imax(I_IN, I) + imax(F_IN, F) + 3;

  logic signed [WX-1:0] aligned;
  logic signed [WX-1:0] rounded;
  logic [W-1:0]         conv;
  logic                 flag;

  logic            vld_d, vld_q;
  logic            ovf_d, ovf_q;
  logic [W-1:0]    dat_d, dat_q;

  fxq_align #(.W_IN(W_IN), .IN_SIGNED(IN_SIGNED), .SHIFT_L(SHIFT_L), .WX(WX)) u_align (
    .i_val (i_data),
    .o_val (aligned)
  );

  fxq_round #(.WX(WX), .DROP(DROP)) u_round (
    .i_val  (aligned),
    .i_mode (i_qmode),
    .o_val  (rounded)
  );

  fxq_ovf #(.WX(WX), .W(W), .OUT_SIGNED(OUT_SIGNED)) u_ovf (
    .i_val  (rounded),
    .i_mode (i_omode),
    .o_val  (conv),
    .o_flag (flag)
  );

  always_comb begin
    vld_d = i_valid;
    ovf_d = i_valid & flag;
    dat_d = dat_q;
    if (i_valid) dat_d = conv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      ovf_q <= ovf_d;
      dat_q <= dat_d;
    end
  end

  assign o_valid = vld_q;
  assign o_ovf   = ovf_q;
  assign o_data  = dat_q;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |=> o_valid); // R14
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |=> (!o_valid && !o_ovf && $stable(o_data))); // R14
  AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    o_ovf |-> o_valid); // R14
endmodule

// File: tb/test_fxq_convert.sv
module test_fxq_convert;
  localparam int CLK_PERIOD = 10;
  localparam int W_IN = 12, I_IN = 5, W = 8, I = 3;
  localparam int D    = (W_IN - I_IN) - (W - I);
  localparam int OMAX = (1 << (W-1)) - 1;
  localparam int OMIN = -(1 << (W-1));

  logic            clk = 1'b0;
  logic            rst_n;
  logic            i_valid;
  logic [W_IN-1:0] i_data;
  logic [2:0]      i_qmode, i_omode;
  logic            o_valid;
  logic [W-1:0]    o_data;
  logic            o_ovf;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    bit    vld;
    int    val;
    bit    flg;
    string tag;
  } exp_t;
  exp_t pend[$];
  int   last_val = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxq_convert i_fxq_convert (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_data(i_data),
    .i_qmode(i_qmode), .i_omode(i_omode),
    .o_valid(o_valid), .o_data(o_data), .o_ovf(o_ovf)
  );

  function automatic int ref_round(int x, int m, output int rem);
    int q0, h;
    bit up;
    q0  = x >>> D;
    rem = x - (q0 * (1 << D));
    h   = 1 << (D-1);
    case (m)
      1: up = (x < 0) && (rem != 0);
      2: up = (rem >= h);
      3: up = (rem > h) || (rem == h && x < 0);
      4: up = (rem > h);
      5: up = (rem > h) || (rem == h && x >= 0);
      6: up = (rem > h) || (rem == h && (q0 % 2 != 0));
      default: up = 1'b0;
    endcase
    return up ? q0 + 1 : q0;
  endfunction

  function automatic int ref_ovf(int q, int m, output bit flg);
    int wr, mag;
    wr = q & ((1 << W) - 1);
    if (wr > OMAX) wr -= (1 << W);
    flg = (q > OMAX) || (q < OMIN);
    case (m)
      1: return (q > OMAX) ? OMAX : (q < OMIN) ? OMIN : q;
      2: return flg ? 0 : q;
      3: begin
        flg = (q > OMAX) || (q < -OMAX);
        return (q > OMAX) ? OMAX : (q < -OMAX) ? -OMAX : q;
      end
      4: begin
        if (!flg) return q;
        mag = ((q < 0) ? -q : q) % (1 << (W-1));
        return (q < 0) ? -mag : mag;
      end
      default: return wr;
    endcase
  endfunction

  function automatic string qtag(int m);
    case (m)
      1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; 6: return "R8";
      default: return "R2";
    endcase
  endfunction

  function automatic string otag(int m);
    case (m)
      1: return "R10"; 2: return "R11"; 3: return "R12"; 4: return "R13";
      default: return "R9";
    endcase
  endfunction

  task automatic check_out();
    exp_t e;
    int   got;
    if (pend.size() == 0) return;
    e   = pend.pop_front();
    got = int'($signed(o_data));
    n_checks++;
    if (o_valid !== e.vld) begin
      n_fail++;
      $display("FAIL R14 o_valid actual %0b expected %0b", o_valid, e.vld);
    end
    n_checks++;
    if (got != e.val) begin
      n_fail++;
      $display("FAIL %s o_data actual %0d expected %0d", e.tag, got, e.val);
    end
    n_checks++;
    if (o_ovf !== e.flg) begin
      n_fail++;
      $display("FAIL %s o_ovf actual %0b expected %0b", e.tag, o_ovf, e.flg);
    end
  endtask

  task automatic step(bit v, int code, int qm, int om);
    exp_t e;
    int   x, q, rem;
    bit   f;
    @(negedge clk);
    check_out();
    i_valid = v;
    i_data  = code[W_IN-1:0];
    i_qmode = qm[2:0];
    i_omode = om[2:0];
    if (v) begin
      x = int'($signed(code[W_IN-1:0]));
      q = ref_round(x, qm, rem);
      e.val = ref_ovf(q, om, f);
      e.flg = f;
      e.vld = 1'b1;
      if (f)             e.tag = otag(om);
      else if (rem == 0) e.tag = "R1";
      else               e.tag = qtag(qm);
      last_val = e.val;
    end else begin
      e.vld = 1'b0; e.val = last_val; e.flg = 1'b0; e.tag = "R14";
    end
    pend.push_back(e);
  endtask

  initial begin
    rst_n   = 1'b0;
    i_valid = 1'b0;
    i_data  = '0;
    i_qmode = '0;
    i_omode = '0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (o_valid !== 1'b0 || o_ovf !== 1'b0 || o_data !== '0) begin
      n_fail++;
      $display("FAIL R14 reset state actual %0b/%0b/%0h expected 0/0/0", o_valid, o_ovf, o_data);
    end
    rst_n = 1'b1;

    // Directed: R1 exact value, R10 carry from rounding, R12 edge at minimum
    step(1, 12'h040, 2, 1);   // R1  +0.5 passes unchanged
    step(1, 12'h1FF, 2, 1);   // R10 rounds to 128 -> clamp 127, flagged
    step(1, 12'hE00, 0, 3);   // R12 -4.0 -> -127, flagged
    step(0, 0, 0, 0);         // R14 idle hold

    // Every rounding rule over all input codes, clamping overflow
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < (1 << W_IN); c++) begin
        step(1, c, m, 1);
        if ((c % 97) == 0) step(0, 0, 0, 0);
      end
    end
    // Every overflow rule over all input codes, rotating rounding rule
    for (int o = 0; o < 8; o++) begin
      for (int c = 0; c < (1 << W_IN); c++) begin
        step(1, c, (c + o) % 8, o);
        if ((c % 89) == 0) step(0, 0, 0, 0);
      end
    end
    step(0, 0, 0, 0);
    @(negedge clk);
    check_out();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule